// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a register datapath and a data memory that is addressed in bytes but read and written one full word at a time. A request gives an access size, a signedness bit for loads, the low byte-offset bits of the address, the register value to store and the word that memory returns for that address. For a load, the unit picks the addressed byte or half-word out of the fetched word, moves it to the bottom of the result and fills the bits above it with zeros or with copies of its top bit. For a store, it places the low byte or low half-word of the register on the lanes it belongs to and raises the matching byte-write strobes.

Load results come out of a single register stage one cycle after the request, marked by a one-cycle valid pulse. The store strobes, store data and the misalignment flag are combinational from the request, so the memory sees them in the request cycle. An access whose offset does not suit its size is only flagged: the write strobes are held low and the load result is still produced.

Top module: `lane_align_unit`

## Requirements
- R1: While reset is held and after it is released with no request, `rsp_valid`, `rsp_misalign` and `rsp_data` are all zero.
- R2: A load with size code 2'b00 and `req_signed` low returns byte lane `req_ofs` of `mem_rdata` (lane k is bits 8k+7..8k, little-endian) in bits 7..0, with every bit above it zero.
- R3: A load with size code 2'b00 and `req_signed` high returns the same byte, with every bit above bit 7 equal to bit 7 of that byte.
- R4: A load with size code 2'b01 returns the half-word chosen by bit 1 of `req_ofs` (bit 1 low: bits 15..0, high: bits 31..16), filled with zeros when `req_signed` is low and with copies of its bit 15 when high.
- R5: A load with size code 2'b10 or 2'b11 returns `mem_rdata` unchanged.
- R6: `rsp_valid` is high for exactly the cycle after each load request and low after store requests and idle cycles; `rsp_data` is the load result for that request.
- R7: An aligned byte store drives `mem_wstrb` = 4'b0001 shifted left by `req_ofs` and `mem_wdata` = the low byte of `req_wdata` repeated on all four lanes.
- R8: An aligned half-word store drives `mem_wstrb` = 4'b0011 shifted left by `req_ofs` and `mem_wdata` = the low 16 bits of `req_wdata` repeated twice.
- R9: An aligned word store (size code 2'b10 or 2'b11) drives `mem_wstrb` = 4'b1111 and `mem_wdata` = `req_wdata`.
- R10: `req_misalign` is high in the request cycle for a valid half-word access with `req_ofs[0]` set or a valid word access with `req_ofs` nonzero, never for byte accesses; such a store drives `mem_wstrb` to zero, and such a load returns `rsp_misalign` high together with its `rsp_valid`.
- R11: `mem_wstrb` is zero whenever there is no valid store request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| req_signed | input | 1 | Load fills with sign copies when high |
| req_ofs | input | 2 | Low address bits: byte offset within the word |
| req_wdata | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word fetched from memory for this request |
| mem_wstrb | output | 4 | Byte-write strobes, bit k for lane k |
| mem_wdata | output | 32 | Store data laid onto the lanes |
| req_misalign | output | 1 | Offset does not suit the access size |
| rsp_valid | output | 1 | Load result present |
| rsp_data | output | 32 | Right-justified, extended load result |
| rsp_misalign | output | 1 | The load now answered was misaligned |

## Verification
The registered load answer of one request and the combinational store strobes of the next fall in the same cycle when a store follows a load directly, and a misaligned load followed by a store lands the delayed flag beside live strobes. The bench runs directed load-then-store pairs and a long random stream in which these pairings occur often. A reference model computes both sides every cycle, so a response that has leaked into the store path or a strobe that has picked up the previous request's state is caught in that very cycle.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE     = 2'b00,
      SZ_HALF     = 2'b01,
      SZ_WORD     = 2'b10,
      SZ_WORD_ALT = 2'b11
   } acc_size_e;

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
   import lane_align_pkg::*;
#(
   parameter int OFS_W = 2
) (
   input  acc_size_e          size,
   input  logic [OFS_W-1:0]   ofs,
   output logic               mis
);

   always_comb begin
      unique case (size)
         SZ_BYTE: mis = 1'b0;
         SZ_HALF: mis = ofs[0];
         default: mis = |ofs;
      endcase
   end

endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
   import lane_align_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1
) (
   input  logic                          wr_en,
   input  acc_size_e                     size,
   input  logic [$clog2(DATA_W/8)-1:0]   ofs,
   input  logic                          mis,
   input  logic [DATA_W-1:0]             src,
   output logic [DATA_W/8-1:0]           strb,
   output logic [DATA_W-1:0]             data
);

   localparam int LANES  = DATA_W / 8;
   localparam int HALVES = LANES / 2;

   logic [LANES-1:0] base_mask;

   always_comb begin
      unique case (size)
         SZ_BYTE: base_mask = LANES'(1);
         SZ_HALF: base_mask = LANES'(3);
         default: base_mask = '1;
      endcase
   end

   assign strb = (wr_en && !mis) ? (base_mask << ofs) : '0;

   if (REPLICATE) begin : g_replicate
      always_comb begin
         unique case (size)
            SZ_BYTE: data = {LANES{src[7:0]}};
            SZ_HALF: data = {HALVES{src[15:0]}};
            default: data = src;
         endcase
      end
   end else begin : g_shift
      always_comb begin
         unique case (size)
            SZ_BYTE: data = DATA_W'(src[7:0])  << {ofs, 3'b000};
            SZ_HALF: data = DATA_W'(src[15:0]) << {ofs, 3'b000};
            default: data = src;
         endcase
      end
   end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
   import lane_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e                     size,
   input  logic                          sgn,
   input  logic [$clog2(DATA_W/8)-1:0]   ofs,
   input  logic [DATA_W-1:0]             word,
   output logic [DATA_W-1:0]             value
);

   localparam int LANES  = DATA_W / 8;
   localparam int HALVES = LANES / 2;
   localparam int OFS_W  = $clog2(LANES);

   logic [7:0]  lane_q [LANES];
   logic [15:0] half_q [HALVES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_q[i] = word[8*i +: 8];
   end

   for (genvar j = 0; j < HALVES; j++) begin : g_half
      assign half_q[j] = word[16*j +: 16];
   end

   logic [7:0]  pick_b;
   logic [15:0] pick_h;

   assign pick_b = lane_q[ofs];
   assign pick_h = half_q[ofs[OFS_W-1:1]];

   always_comb begin
      unique case (size)
         SZ_BYTE: value = {{(DATA_W-8){sgn & pick_b[7]}}, pick_b};
         SZ_HALF: value = {{(DATA_W-16){sgn & pick_h[15]}}, pick_h};
         default: value = word;
      endcase
   end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
   import lane_align_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [1:0]                    req_size,
   input  logic                          req_signed,
   input  logic [$clog2(DATA_W/8)-1:0]   req_ofs,
   input  logic [DATA_W-1:0]             req_wdata,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic [DATA_W/8-1:0]           mem_wstrb,
   output logic [DATA_W-1:0]             mem_wdata,
   output logic                          req_misalign,
   output logic                          rsp_valid,
   output logic [DATA_W-1:0]             rsp_data,
   output logic                          rsp_misalign
);

   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = $clog2(LANES);

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("lane_align_unit: DATA_W must be a power of two, at least 32");
   end

   acc_size_e  size_e;
   logic       mis;
   logic       is_load;
   logic       is_store;
   logic [DATA_W-1:0] load_val;

   assign size_e   = acc_size_e'(req_size);
   assign is_load  = req_valid && !req_write;
   assign is_store = req_valid &&  req_write;

   lane_align_check #(.OFS_W(OFS_W)) u_check (
      .size (size_e),
      .ofs  (req_ofs),
      .mis  (mis)
   );

   lane_store_pack #(.DATA_W(DATA_W), .REPLICATE(REPLICATE)) u_pack (
      .wr_en (is_store),
      .size  (size_e),
      .ofs   (req_ofs),
      .mis   (mis),
      .src   (req_wdata),
      .strb  (mem_wstrb),
      .data  (mem_wdata)
   );

   lane_load_extract #(.DATA_W(DATA_W)) u_extract (
      .size  (size_e),
      .sgn   (req_signed),
      .ofs   (req_ofs),
      .word  (mem_rdata),
      .value (load_val)
   );

   assign req_misalign = req_valid && mis;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_misalign <= 1'b0;
         rsp_data     <= '0;
      end else begin
         rsp_valid    <= is_load;
         rsp_misalign <= is_load && mis;
         if (is_load) begin
            rsp_data <= load_val;
         end
      end
   end

   // R6: each load request gets a response pulse on the next cycle
   p_rsp_follows_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   // R6: no response without a load request one cycle earlier
   p_rsp_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   // R2: unsigned byte loads are zero above bit 7
   p_zero_fill_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_size == 2'b00 && !req_signed))
      |-> rsp_data[DATA_W-1:8] == '0);

   // R3: signed byte loads repeat bit 7 upward
   p_sign_fill_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_size == 2'b00 && req_signed))
      |-> rsp_data[DATA_W-1:8] == {(DATA_W-8){rsp_data[7]}});

   // R10: a flagged access never writes
   p_strobe_off_mis_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_misalign |-> mem_wstrb == '0);

   // R11: strobes stay low outside store requests
   p_idle_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |-> mem_wstrb == '0);

   // R7: a byte store touches exactly one lane
   p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 2'b00) |-> $countones(mem_wstrb) == 1);

   // R9: an aligned word store touches every lane
   p_word_all_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size[1] && !req_misalign) |-> mem_wstrb == '1);

endmodule

// File: tb/tb_lane_align_unit.sv
module tb_lane_align_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic [1:0]  req_ofs = 2'b00;
   logic [31:0] req_wdata = '0;
   logic [31:0] mem_rdata = '0;
   logic [3:0]  mem_wstrb;
   logic [31:0] mem_wdata;
   logic        req_misalign;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_misalign;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // pending expected response
   bit          e_v = 1'b0;
   bit          e_m = 1'b0;
   logic [31:0] e_d = '0;
   string       e_tag = "R6";

   always #10 clk = ~clk;

   lane_align_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_signed(req_signed), .req_ofs(req_ofs),
      .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_wstrb(mem_wstrb),
      .mem_wdata(mem_wdata), .req_misalign(req_misalign), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_misalign(rsp_misalign)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic sg,
                                            input logic [1:0] ofs, input logic [31:0] w);
      int unsigned v;
      if (sz == 2'b00) begin
         v = (w >> (8 * int'(ofs))) & 32'hFF;
         if (sg && v >= 128) v = v | 32'hFFFF_FF00;
      end else if (sz == 2'b01) begin
         v = (w >> (16 * int'(ofs[1]))) & 32'hFFFF;
         if (sg && v >= 32768) v = v | 32'hFFFF_0000;
      end else begin
         v = w;
      end
      return v;
   endfunction

   function automatic bit ref_mis(input logic [1:0] sz, input logic [1:0] ofs);
      if (sz == 2'b00) return 1'b0;
      if (sz == 2'b01) return ofs[0];
      return ofs != 2'b00;
   endfunction

   function automatic string size_tag_ld(input logic [1:0] sz, input logic sg);
      if (sz == 2'b00) return sg ? "R3" : "R2";
      if (sz == 2'b01) return "R4";
      return "R5";
   endfunction

   // one cycle: check last response, drive a request, check combinational outputs
   task automatic step(input bit v, input bit w, input logic [1:0] sz, input bit sg,
                       input logic [1:0] ofs, input logic [31:0] wd, input logic [31:0] rd);
      logic [3:0]  x_strb;
      logic [31:0] x_wdata;
      bit          x_mis;
      string       st;
      @(negedge clk);
      chk("R6 rsp_valid", 32'(rsp_valid), 32'(e_v));
      if (e_v) begin
         chk({e_tag, " rsp_data"}, rsp_data, e_d);
         chk("R10 rsp_misalign", 32'(rsp_misalign), 32'(e_m));
      end
      req_valid = v; req_write = w; req_size = sz; req_signed = sg;
      req_ofs = ofs; req_wdata = wd; mem_rdata = rd;
      #2;
      x_mis = v && ref_mis(sz, ofs);
      chk("R10 req_misalign", 32'(req_misalign), 32'(x_mis));
      if (!(v && w) || x_mis) x_strb = 4'b0000;
      else if (sz == 2'b00)   x_strb = 4'b0001 << ofs;
      else if (sz == 2'b01)   x_strb = 4'b0011 << ofs;
      else                    x_strb = 4'b1111;
      if (!(v && w))    st = "R11";
      else if (x_mis)   st = "R10";
      else if (sz == 2'b00) st = "R7";
      else if (sz == 2'b01) st = "R8";
      else              st = "R9";
      chk({st, " mem_wstrb"}, 32'(mem_wstrb), 32'(x_strb));
      if (v && w) begin
         if (sz == 2'b00)      x_wdata = {4{wd[7:0]}};
         else if (sz == 2'b01) x_wdata = {2{wd[15:0]}};
         else                  x_wdata = wd;
         chk(sz == 2'b00 ? "R7 mem_wdata" : (sz == 2'b01 ? "R8 mem_wdata" : "R9 mem_wdata"),
             mem_wdata, x_wdata);
      end
      e_v   = v && !w;
      e_m   = x_mis;
      e_d   = ref_load(sz, sg, ofs, rd);
      e_tag = size_tag_ld(sz, sg);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R1 rsp_misalign", 32'(rsp_misalign), 32'd0);
      chk("R1 rsp_data", rsp_data, 32'd0);
      rst_n = 1'b1;
      step(0, 0, 2'b00, 0, 2'b00, 32'h0, 32'h0);
      @(negedge clk);
      chk("R1 rsp_valid after release", 32'(rsp_valid), 32'd0);
      chk("R1 rsp_data after release", rsp_data, 32'd0);

      // R2/R3: every byte lane, both fills
      for (int o = 0; o < 4; o++) begin
         step(1, 0, 2'b00, 0, 2'(o), 32'h0, 32'h80F1_7F8E);
         step(1, 0, 2'b00, 1, 2'(o), 32'h0, 32'h80F1_7F8E);
      end
      // R4: both halves, both fills, sign bit set and clear
      for (int o = 0; o < 4; o += 2) begin
         step(1, 0, 2'b01, 0, 2'(o), 32'h0, 32'h9ABC_7123);
         step(1, 0, 2'b01, 1, 2'(o), 32'h0, 32'h9ABC_7123);
      end
      // R5: word with both size codes
      step(1, 0, 2'b10, 1, 2'b00, 32'h0, 32'hDEAD_BEEF);
      step(1, 0, 2'b11, 0, 2'b00, 32'h0, 32'h0123_4567);
      // R7/R8/R9: stores on every offset
      for (int o = 0; o < 4; o++) step(1, 1, 2'b00, 0, 2'(o), 32'hAABB_CCDD, 32'h0);
      step(1, 1, 2'b01, 0, 2'b00, 32'h1122_3344, 32'h0);
      step(1, 1, 2'b01, 0, 2'b10, 32'h1122_3344, 32'h0);
      step(1, 1, 2'b10, 0, 2'b00, 32'hCAFE_F00D, 32'h0);
      // R10: misaligned stores and loads
      step(1, 1, 2'b01, 0, 2'b01, 32'hFFFF_FFFF, 32'h0);
      step(1, 1, 2'b10, 0, 2'b11, 32'hFFFF_FFFF, 32'h0);
      step(1, 0, 2'b01, 1, 2'b11, 32'h0, 32'h8000_8001);
      step(1, 0, 2'b11, 0, 2'b10, 32'h0, 32'h5555_AAAA);
      // load immediately followed by store: response and strobes share a cycle
      step(1, 0, 2'b00, 1, 2'b11, 32'h0, 32'hF000_0000);
      step(1, 1, 2'b00, 0, 2'b01, 32'h0000_0077, 32'hFFFF_FFFF);
      step(1, 0, 2'b10, 0, 2'b01, 32'h0, 32'h1234_5678);
      step(1, 1, 2'b01, 0, 2'b10, 32'h0000_BEEF, 32'h0);
      // R11: idle with write asserted but no valid
      step(0, 1, 2'b10, 0, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      step(0, 0, 2'b00, 0, 2'b00, 32'h0, 32'h0);

      // random stream
      for (int n = 0; n < 3000; n++) begin
         step(1'($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom), 1'($urandom),
              2'($urandom), $urandom, $urandom);
      end
      step(0, 0, 2'b00, 0, 2'b00, 32'h0, 32'h0);
      step(0, 0, 2'b00, 0, 2'b00, 32'h0, 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule